// File: doc/BRIEF.md
# NAND On-Die ECC Status Collector

After a NAND device that corrects its own errors has finished a page or subpage read, this block asks the device how much correction it performed. It sends an ECC-status command on a small NAND bus and waits out the address-to-data gap. It then reads one status byte for each 512-byte correction step of the read and decodes each byte into a per-step bitflip count or an uncorrectable flag.

For one collection the block reports three values: the worst correctable step, the sum of corrected bits, and the number of uncorrectable steps. These are shown during a one-cycle `done` pulse. Two free-running totals sum the corrected bits and the failed steps over all collections since reset.

When the ECC-status command is not supported by the device, the caller raises `fallback` together with `start`. The block then sends the ordinary status command and reads a single byte. Bit 0 of that byte means a failure. Bit 3 means a rewrite is recommended, and in that case the block reports the configured threshold as the bitflip value.

Top module: `nand_ecc_status_collector`

## Requirements
- R1: After reset, `done`, `nand_cle` and `nand_re` are low and `max_flips`, `corr_inc`, `fail_inc`, `corr_total` and `fail_total` are zero.
- R2: A collection accepted with `fallback` low drives `nand_cle` high for exactly one cycle with `nand_cmd` = 0x7A. With `fallback` high the command byte is 0x70. `nand_cle` and `nand_re` are never high together.
- R3: The first `nand_re` cycle comes exactly `ADL_CYC` idle cycles after the `nand_cle` cycle. There is never fewer.
- R4: The number of `nand_re` cycles is the clamped step count: 1 when `num_steps` is 0, `MAX_STEPS` when it exceeds `MAX_STEPS`, and `num_steps` otherwise. In fallback mode the number is exactly one. `nand_din` is sampled at the clock edge that ends each `nand_re` cycle.
- R5: Only bits [3:0] of each ECC status byte are decoded. Bits [7:4] have no effect on any output.
- R6: A step whose low nibble is 0xF adds one to `fail_inc` and `fail_total` and adds nothing to `corr_inc` or `max_flips`.
- R7: Any other nibble value is that step's bitflip count. It is added to `corr_inc` and `corr_total`, and `max_flips` is the largest such count over the collection (0 if none).
- R8: In fallback mode, status bit 0 set gives `fail_inc` = 1, `max_flips` = 0 and `corr_inc` = 0.
- R9: In fallback mode with bit 0 clear, bit 3 set gives `max_flips` = `corr_inc` = `rewrite_thr`. With both bits clear, all three results are 0.
- R10: `done` is high for exactly one cycle per collection, and the results are valid in that cycle. A `start` raised while a collection is running is ignored.
- R11: `corr_total` and `fail_total` add up every collection's increments since reset and change only while status bytes are being captured.
- R12: `max_flips`, `corr_inc` and `fail_inc` clear when a collection is accepted, so no value carries over from an earlier collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a collection (taken when idle) |
| fallback | input | 1 | Use the ordinary status read for this collection |
| num_steps | input | STEP_W | ECC steps in the read just completed |
| rewrite_thr | input | 4 | Bitflip value reported on a rewrite-recommended status |
| nand_cle | output | 1 | Command latch enable |
| nand_re | output | 1 | Read strobe, one byte per high cycle |
| nand_cmd | output | 8 | Command byte, valid while `nand_cle` is high |
| nand_din | input | 8 | Byte returned by the device |
| done | output | 1 | One-cycle end-of-collection pulse |
| max_flips | output | 4 | Worst correctable step of the collection |
| corr_inc | output | INC_W | Corrected bits in the collection |
| fail_inc | output | STEP_W | Uncorrectable steps in the collection |
| corr_total | output | TOT_W | Running corrected-bit total |
| fail_total | output | TOT_W | Running failed-step total |

## Verification
The bench builds the block with `MAX_STEPS` = 8, `ADL_CYC` = 4 and `TOT_W` = 16. A short wait makes the address-to-data gap cheap to measure exactly, and eight steps allow every step count to be driven, including the clamped values 0 and 9. It sweeps all sixteen status nibbles with varying upper bits, a grid of multi-step patterns at every step count, and every low-nibble fallback status paired with different thresholds. The totals are followed across the whole run, which keeps them far from wrapping at 16 bits.

// File: rtl/ecsc_pkg.sv
package ecsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } ecsc_state_t;

  localparam logic [7:0] CMD_ECC_STAT = 8'h7A;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam int         NIB_W        = 4;
  localparam logic [NIB_W-1:0] NIB_UNCORR = 4'hF;
  localparam int         NIB_MAX_OK   = 14;
endpackage

// File: rtl/ecsc_seq.sv
module ecsc_seq
  import ecsc_pkg::*;
#(
  parameter  int MAX_STEPS = 8,
  parameter  int ADL_CYC   = 14,
  localparam int STEP_W    = $clog2(MAX_STEPS + 1),
  localparam int WAIT_W    = $clog2(ADL_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fallback,
  input  logic [STEP_W-1:0] num_steps,
  output logic              cle,
  output logic              re,
  output logic [7:0]        cmd,
  output logic              cap,
  output logic              clr,
  output logic              fb_mode,
  output logic              done
);
  ecsc_state_t       state;
  logic [WAIT_W-1:0] wcnt;
  logic [STEP_W-1:0] idx;
  logic [STEP_W-1:0] n_q;
  logic [STEP_W-1:0] n_eff;

  always_comb begin
    if (num_steps == '0)
      n_eff = STEP_W'(1);
    else if (num_steps > STEP_W'(MAX_STEPS))
      n_eff = STEP_W'(MAX_STEPS);
    else
      n_eff = num_steps;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      idx     <= '0;
      n_q     <= STEP_W'(1);
      fb_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_CMD;
          fb_mode <= fallback;
          n_q     <= fallback ? STEP_W'(1) : n_eff;
        end
        ST_CMD: begin
          state <= ST_WAIT;
          wcnt  <= '0;
        end
        ST_WAIT: begin
          if (wcnt == WAIT_W'(ADL_CYC - 1)) begin
            state <= ST_READ;
            idx   <= '0;
          end else begin
            wcnt <= wcnt + WAIT_W'(1);
          end
        end
        ST_READ: begin
          if (idx == n_q - STEP_W'(1)) state <= ST_DONE;
          else                          idx   <= idx + STEP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cle  = (state == ST_CMD);
  assign cmd  = cle ? (fb_mode ? CMD_STATUS : CMD_ECC_STAT) : 8'h00;
  assign re   = (state == ST_READ);
  assign cap  = re;
  assign done = (state == ST_DONE);
  assign clr  = (state == ST_IDLE) && start;

  // Observation counters for the bus-timing properties
  logic [WAIT_W-1:0] gap_cnt;
  logic [STEP_W-1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      rd_cnt  <= '0;
    end else begin
      if (cle)                               gap_cnt <= '0;
      else if (gap_cnt != WAIT_W'(ADL_CYC))  gap_cnt <= gap_cnt + WAIT_W'(1);
      if (cle)                               rd_cnt  <= '0;
      else if (re)                           rd_cnt  <= rd_cnt + STEP_W'(1);
    end
  end

  AST_CLE_RE_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle && re)); // R2
  AST_CLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) cle |=> !cle); // R2
  AST_ADL_GAP: assert property (@(posedge clk) disable iff (rst) (re && !$past(re)) |-> (gap_cnt >= WAIT_W'(ADL_CYC))); // R3
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (rst) re |-> (rd_cnt < STEP_W'(MAX_STEPS))); // R4
endmodule

// File: rtl/ecsc_decode.sv
module ecsc_decode
  import ecsc_pkg::*;
(
  input  logic             fb_mode,
  input  logic [7:0]       din,
  input  logic [NIB_W-1:0] rewrite_thr,
  output logic             step_fail,
  output logic [NIB_W-1:0] step_flips
);
  logic [NIB_W-1:0] nib;
  logic             unused_hi;

  assign nib       = din[NIB_W-1:0];
  assign unused_hi = ^din[7:NIB_W];

  always_comb begin
    if (fb_mode) begin
      step_fail  = din[0];
      step_flips = (!din[0] && din[3]) ? rewrite_thr : '0;
    end else begin
      step_fail  = (nib == NIB_UNCORR);
      step_flips = step_fail ? '0 : nib;
    end
  end
endmodule

// File: rtl/ecsc_accum.sv
module ecsc_accum
  import ecsc_pkg::*;
#(
  parameter  int MAX_STEPS = 8,
  parameter  int TOT_W     = 16,
  localparam int STEP_W    = $clog2(MAX_STEPS + 1),
  localparam int INC_W     = $clog2(MAX_STEPS * NIB_MAX_OK + 16)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic              step_fail,
  input  logic [NIB_W-1:0]  step_flips,
  output logic [NIB_W-1:0]  max_q,
  output logic [INC_W-1:0]  corr_q,
  output logic [STEP_W-1:0] fail_q,
  output logic [TOT_W-1:0]  corr_tot,
  output logic [TOT_W-1:0]  fail_tot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      max_q    <= '0;
      corr_q   <= '0;
      fail_q   <= '0;
      corr_tot <= '0;
      fail_tot <= '0;
    end else if (clr) begin
      max_q  <= '0;
      corr_q <= '0;
      fail_q <= '0;
    end else if (cap) begin
      if (step_fail) begin
        fail_q   <= fail_q + STEP_W'(1);
        fail_tot <= fail_tot + TOT_W'(1);
      end else begin
        corr_q   <= corr_q + INC_W'(step_flips);
        corr_tot <= corr_tot + TOT_W'(step_flips);
        if (step_flips > max_q) max_q <= step_flips;
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) clr |=> (max_q == '0 && corr_q == '0 && fail_q == '0)); // R12
  AST_TOTALS_HOLD: assert property (@(posedge clk) disable iff (rst) !cap |=> ($stable(corr_tot) && $stable(fail_tot))); // R11
  AST_FAIL_NO_CORR: assert property (@(posedge clk) disable iff (rst) (cap && step_fail) |=> $stable(corr_q)); // R6
endmodule

// File: rtl/nand_ecc_status_collector.sv
module nand_ecc_status_collector
  import ecsc_pkg::*;
#(
  parameter  int MAX_STEPS = 8,
  parameter  int ADL_CYC   = 14,
  parameter  int TOT_W     = 16,
  localparam int STEP_W    = $clog2(MAX_STEPS + 1),
  localparam int INC_W     = $clog2(MAX_STEPS * NIB_MAX_OK + 16)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fallback,
  input  logic [STEP_W-1:0] num_steps,
  input  logic [3:0]        rewrite_thr,
  output logic              nand_cle,
  output logic              nand_re,
  output logic [7:0]        nand_cmd,
  input  logic [7:0]        nand_din,
  output logic              done,
  output logic [3:0]        max_flips,
  output logic [INC_W-1:0]  corr_inc,
  output logic [STEP_W-1:0] fail_inc,
  output logic [TOT_W-1:0]  corr_total,
  output logic [TOT_W-1:0]  fail_total
);
  logic             cap, clr, fb_mode;
  logic             step_fail;
  logic [NIB_W-1:0] step_flips;

  ecsc_seq #(.MAX_STEPS(MAX_STEPS), .ADL_CYC(ADL_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fallback(fallback),
    .num_steps(num_steps), .cle(nand_cle), .re(nand_re), .cmd(nand_cmd),
    .cap(cap), .clr(clr), .fb_mode(fb_mode), .done(done)
  );

  ecsc_decode u_dec (
    .fb_mode(fb_mode), .din(nand_din), .rewrite_thr(rewrite_thr),
    .step_fail(step_fail), .step_flips(step_flips)
  );

  ecsc_accum #(.MAX_STEPS(MAX_STEPS), .TOT_W(TOT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clr), .cap(cap),
    .step_fail(step_fail), .step_flips(step_flips),
    .max_q(max_flips), .corr_q(corr_inc), .fail_q(fail_inc),
    .corr_tot(corr_total), .fail_tot(fail_total)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_MAX_IN_SUM: assert property (@(posedge clk) disable iff (rst) done |-> (INC_W'(max_flips) <= corr_inc)); // R7
  AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (rst) done |-> (fail_inc <= STEP_W'(MAX_STEPS))); // R6
endmodule

// File: tb/sim_nand_ecc_status_collector.sv
`timescale 1ns/1ps
module sim_nand_ecc_status_collector;
  localparam int MAXS  = 8;
  localparam int ADL   = 4;
  localparam int TOTW  = 16;
  localparam int SW    = $clog2(MAXS + 1);
  localparam int IW    = $clog2(MAXS * 14 + 16);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, fallback = 1'b0;
  logic [SW-1:0] num_steps = '0;
  logic [3:0] rewrite_thr = '0;
  logic nand_cle, nand_re, done;
  logic [7:0] nand_cmd;
  logic [7:0] nand_din = 8'h00;
  logic [3:0] max_flips;
  logic [IW-1:0] corr_inc;
  logic [SW-1:0] fail_inc;
  logic [TOTW-1:0] corr_total, fail_total;

  always #2.5 clk = ~clk;

  nand_ecc_status_collector #(.MAX_STEPS(MAXS), .ADL_CYC(ADL), .TOT_W(TOTW)) u0 (
    .clk(clk), .rst(rst), .start(start), .fallback(fallback),
    .num_steps(num_steps), .rewrite_thr(rewrite_thr),
    .nand_cle(nand_cle), .nand_re(nand_re), .nand_cmd(nand_cmd),
    .nand_din(nand_din), .done(done), .max_flips(max_flips),
    .corr_inc(corr_inc), .fail_inc(fail_inc),
    .corr_total(corr_total), .fail_total(fail_total)
  );

  int total = 0, bad = 0;
  int cyc = 0, cle_cyc = 0, first_re_cyc = 0;
  int cle_cnt = 0, strobe_cnt = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] dev_bytes [0:MAXS-1];
  int exp_ctot = 0, exp_ftot = 0;

  // Device model: answers each read strobe with the next queued byte
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (nand_cle) begin
      cle_cnt  = cle_cnt + 1;
      cle_cyc  = cyc;
      last_cmd = nand_cmd;
    end
    if (nand_re) begin
      if (strobe_cnt == 0) first_re_cyc = cyc;
      nand_din   = (strobe_cnt < MAXS) ? dev_bytes[strobe_cnt] : 8'h00;
      strobe_cnt = strobe_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic collect(input bit fb, input int n, input int thr, input bit poke);
    int neff, emax, ecorr, efail, waitc;
    neff = fb ? 1 : (n == 0) ? 1 : (n > MAXS) ? MAXS : n;
    emax = 0; ecorr = 0; efail = 0;
    for (int i = 0; i < neff; i++) begin
      int nib;
      nib = dev_bytes[i] & 15;
      if (fb) begin
        if (dev_bytes[i][0]) efail = 1;
        else if (dev_bytes[i][3]) begin emax = thr; ecorr = thr; end
      end else if (nib == 15) efail++;
      else begin
        ecorr += nib;
        if (nib > emax) emax = nib;
      end
    end
    exp_ctot += ecorr; exp_ftot += efail;
    cle_cnt = 0; strobe_cnt = 0;
    fallback = fb; num_steps = SW'(n); rewrite_thr = 4'(thr);
    start = 1'b1;
    step();
    start = 1'b0;
    if (poke) begin
      step(); step();
      start = 1'b1; fallback = ~fb; num_steps = SW'(MAXS);
      step();
      start = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 200) begin step(); waitc++; end
    chk("R10 done seen", int'(done), 1);
    chk("R2 command byte", int'(last_cmd), fb ? 8'h70 : 8'h7A);
    chk("R2 one cle cycle", cle_cnt, 1);
    chk("R3 adl gap", first_re_cyc - cle_cyc - 1, ADL);
    chk("R4 strobe count", strobe_cnt, neff);
    chk(fb ? "R8/R9 max_flips" : "R7 max_flips", int'(max_flips), emax);
    chk(fb ? "R9 corr_inc" : "R7 corr_inc", int'(corr_inc), ecorr);
    chk(fb ? "R8 fail_inc" : "R6 fail_inc", int'(fail_inc), efail);
    chk("R11 corr_total", int'(corr_total), exp_ctot);
    chk("R11 fail_total", int'(fail_total), exp_ftot);
    step();
    chk("R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MAXS; i++) dev_bytes[i] = 8'h00;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 cle", int'(nand_cle), 0);
    chk("R1 re", int'(nand_re), 0);
    chk("R1 max_flips", int'(max_flips), 0);
    chk("R1 corr_inc", int'(corr_inc), 0);
    chk("R1 fail_inc", int'(fail_inc), 0);
    chk("R1 totals", int'(corr_total) + int'(fail_total), 0);

    // R5 R6 R7: every nibble with varied upper bits, one step
    for (int v = 0; v < 16; v++) begin
      dev_bytes[0] = {4'((v * 3 + 5) & 15), 4'(v)};
      collect(1'b0, 1, 0, 1'b0);
    end

    // R4 R6 R7 R12: all step counts including clamped 0 and 9
    for (int n = 0; n <= MAXS + 1; n++) begin
      for (int p = 0; p < 6; p++) begin
        for (int i = 0; i < MAXS; i++)
          dev_bytes[i] = {4'((p * i + n) & 15), 4'((i * 7 + p * 13 + n) % 16)};
        collect(1'b0, n, 0, 1'b0);
      end
    end

    // R12: collection of zeros right after failures
    for (int i = 0; i < MAXS; i++) dev_bytes[i] = 8'hFF;
    collect(1'b0, MAXS, 0, 1'b0);
    for (int i = 0; i < MAXS; i++) dev_bytes[i] = 8'hA0;
    collect(1'b0, MAXS, 0, 1'b0);

    // R8 R9: fallback over all low nibbles, varied thresholds
    for (int s = 0; s < 16; s++) begin
      dev_bytes[0] = {4'(15 - s), 4'(s)};
      collect(1'b1, 5, (s ^ 5) & 15, 1'b0);
    end

    // R10: start while busy is ignored
    for (int i = 0; i < MAXS; i++) dev_bytes[i] = 8'(i + 1);
    collect(1'b0, 3, 0, 1'b1);
    collect(1'b1, 2, 9, 1'b1);

    finish_run();
  end
endmodule